// File: doc/BRIEF.md
# Transmit Power Ramp Envelope Generator

This block produces the digital code sequence for a 10-bit DAC that shapes the rising and falling power edges of radio transmit bursts. Two edge shapes, one for ramp-up and one for ramp-down, are held in a small rewritable table of 16 coarse points each. Each point is a 5-bit fraction of the distance from the level at ramp start to the ramp's target level.

A ramp begins on an up or down strobe from an external timing-window source. The strobe also samples the burst level as the target. The generator then walks the selected shape at one output step every six clocks, which is 13 MHz divided by 6. It interpolates four sub-steps between neighbouring coarse points, so each edge has 64 interpolated codes, followed by a final code equal to the target.

A down strobe with a non-zero level moves the envelope from one burst's power straight to the next burst's power, so multislot bursts chain without a return to zero. A down strobe with level zero ends transmission. A strobe that arrives while a ramp runs is held until that ramp ends.

Top module: `ramp_env_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `dac_code` is 0 and `dac_valid` is 0.
- R2: A cycle with `shape_we` high stores `shape_wdata` into entry `shape_addr` of the up table when `shape_sel` is 0, or of the down table when `shape_sel` is 1.
- R3: With no ramp running and none held, a strobe starts a ramp. Its start level is the present `dac_code` and its target is `burst_level` sampled with the strobe. `up_strobe` selects the up table and `down_strobe` selects the down table. The first update of the ramp equals the start level.
- R4: A running ramp updates `dac_code` exactly every 6 clocks. The first update comes at the 6th rising edge after the edge that sampled the strobe. `dac_valid` is high for the single cycle following each update and low in all other cycles.
- R5: Update number j (0 to 63) uses point k = j/4 and sub-step s = j mod 4. It computes f = p*(4-s) + c*s, where c is table entry k and p is entry k-1 (taken as 0 when k is 0). The code is start + floor((target-start)*f/128).
- R6: Update number 64 sets `dac_code` to the target exactly, and the ramp ends.
- R7: Outside the updates of R4, `dac_code` holds its value. After a ramp-down to level 0 it therefore stays at 0.
- R8: A strobe sampled while a ramp runs is held, and a later strobe replaces the held one. The held ramp starts on the edge after the update of R6, so its first update comes 7 clocks after that update.
- R9: If `up_strobe` and `down_strobe` are both high in the same cycle, the ramp uses the down table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (13 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| shape_we | input | 1 | Shape table write enable |
| shape_sel | input | 1 | Table select: 0 up, 1 down |
| shape_addr | input | 4 | Coarse point index |
| shape_wdata | input | 5 | Fraction value, units of 1/32 |
| burst_level | input | 10 | Target level sampled with a strobe |
| up_strobe | input | 1 | Start a rising edge |
| down_strobe | input | 1 | Start a falling or inter-burst edge |
| dac_code | output | 10 | Envelope code to the DAC |
| dac_valid | output | 1 | One-cycle flag after each update |

## Verification
Every internal state shows up in the code of some update. A wrong coarse index, sub-step count or remembered previous point changes the value at the next update, which is at most six clocks away. A wrong start or target level is visible from the second update onward and at the final snap. A held strobe that is lost, not replaced, or started late shows at the first update of the following ramp, which the bench expects exactly seven clocks after the previous final code.

// File: rtl/ramp_env_pkg.sv
package ramp_env_pkg;
  typedef enum logic {
    SHAPE_UP   = 1'b0,
    SHAPE_DOWN = 1'b1
  } shape_kind_e;
endpackage

// File: rtl/ramp_shape_ram.sv
module ramp_shape_ram #(
  parameter int SHAPE_N = 16,
  parameter int SHAPE_W = 5
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic                       wsel,
  input  logic [$clog2(SHAPE_N)-1:0] waddr,
  input  logic [SHAPE_W-1:0]         wdata,
  input  logic                       rsel,
  input  logic [$clog2(SHAPE_N)-1:0] raddr,
  output logic [SHAPE_W-1:0]         rdata
);
  localparam int IDX_W = $clog2(SHAPE_N);
  localparam int DEPTH = 2 * SHAPE_N;

  logic [SHAPE_W-1:0] mem [DEPTH];

  // one write port, one registered read port: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[{wsel, waddr}] <= wdata;
    rdata <= mem[{rsel, raddr}];
  end
endmodule

// File: rtl/ramp_step_timer.sv
module ramp_step_timer #(
  parameter int STEP_DIV = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int CNT_W = (STEP_DIV > 2) ? $clog2(STEP_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_DIV - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/ramp_interp.sv
module ramp_interp #(
  parameter int LVL_W   = 10,
  parameter int SHAPE_W = 5,
  parameter int SUB_W   = 2
) (
  input  logic [LVL_W-1:0]   base,
  input  logic [LVL_W-1:0]   target,
  input  logic [SHAPE_W-1:0] prev_pt,
  input  logic [SHAPE_W-1:0] cur_pt,
  input  logic [SUB_W-1:0]   sub,
  output logic [LVL_W-1:0]   level
);
  localparam int F_W   = SHAPE_W + SUB_W + 1;
  localparam int P_W   = LVL_W + F_W + 3;
  localparam int SHIFT = SHAPE_W + SUB_W;
  localparam logic [F_W-1:0] SUB_N = F_W'(2 ** SUB_W);
  localparam logic signed [P_W-1:0] TOP = P_W'((2 ** LVL_W) - 1);

  logic        [F_W-1:0]   frac;
  logic signed [LVL_W:0]   diff;
  logic signed [P_W-1:0]   prod;
  logic signed [P_W-1:0]   sum;

  always_comb begin
    frac = F_W'(prev_pt) * (SUB_N - F_W'(sub)) + F_W'(cur_pt) * F_W'(sub);
    diff = $signed({1'b0, target}) - $signed({1'b0, base});
    prod = P_W'(diff) * P_W'($signed({1'b0, frac}));
    sum  = P_W'($signed({1'b0, base})) + (prod >>> SHIFT);
    if (sum < 0)        level = '0;
    else if (sum > TOP) level = '1;
    else                level = sum[LVL_W-1:0];
  end
endmodule

// File: rtl/ramp_env_gen.sv
module ramp_env_gen #(
  parameter int LVL_W     = 10,
  parameter int SHAPE_N   = 16,
  parameter int SHAPE_W   = 5,
  parameter int SUB_STEPS = 4,
  parameter int STEP_DIV  = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       shape_we,
  input  logic                       shape_sel,
  input  logic [$clog2(SHAPE_N)-1:0] shape_addr,
  input  logic [SHAPE_W-1:0]         shape_wdata,
  input  logic [LVL_W-1:0]           burst_level,
  input  logic                       up_strobe,
  input  logic                       down_strobe,
  output logic [LVL_W-1:0]           dac_code,
  output logic                       dac_valid
);
  import ramp_env_pkg::*;

  localparam int IDX_W  = $clog2(SHAPE_N);
  localparam int SUB_W  = $clog2(SUB_STEPS);
  localparam int J_W    = IDX_W + SUB_W + 1;
  localparam logic [J_W-1:0]   LAST_J  = J_W'(SHAPE_N * SUB_STEPS);
  localparam logic [SUB_W-1:0] SUB_END = SUB_W'(SUB_STEPS - 1);

  initial begin
    if (STEP_DIV < 3) $error("STEP_DIV must be at least 3 for the read latency");
  end

  shape_kind_e         kind_q;
  logic                busy;
  logic [J_W-1:0]      step_j;
  logic [SHAPE_W-1:0]  prev_pt;
  logic [LVL_W-1:0]    base_q, tgt_q;
  logic                pend_v, pend_dn;
  logic [LVL_W-1:0]    pend_lvl;
  logic                tick, start, trig_now, start_dn;
  logic [LVL_W-1:0]    start_tgt, interp_lvl;
  logic [SHAPE_W-1:0]  cur_pt;
  logic [IDX_W-1:0]    pt_idx;
  logic [SUB_W-1:0]    sub;

  assign pt_idx    = step_j[SUB_W +: IDX_W];
  assign sub       = step_j[SUB_W-1:0];
  assign trig_now  = up_strobe | down_strobe;
  assign start     = !busy && (pend_v || trig_now);
  assign start_dn  = pend_v ? pend_dn  : down_strobe;   // down wins a tie
  assign start_tgt = pend_v ? pend_lvl : burst_level;

  ramp_shape_ram #(.SHAPE_N(SHAPE_N), .SHAPE_W(SHAPE_W)) u_ram (
    .clk   (clk),
    .we    (shape_we),
    .wsel  (shape_sel),
    .waddr (shape_addr),
    .wdata (shape_wdata),
    .rsel  (kind_q == SHAPE_DOWN),
    .raddr (pt_idx),
    .rdata (cur_pt)
  );

  ramp_step_timer #(.STEP_DIV(STEP_DIV)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (start),
    .tick    (tick)
  );

  ramp_interp #(.LVL_W(LVL_W), .SHAPE_W(SHAPE_W), .SUB_W(SUB_W)) u_interp (
    .base    (base_q),
    .target  (tgt_q),
    .prev_pt (prev_pt),
    .cur_pt  (cur_pt),
    .sub     (sub),
    .level   (interp_lvl)
  );

  // ramp engine
  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      kind_q    <= SHAPE_UP;
      step_j    <= '0;
      prev_pt   <= '0;
      base_q    <= '0;
      tgt_q     <= '0;
      dac_code  <= '0;
      dac_valid <= 1'b0;
    end else begin
      dac_valid <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        kind_q  <= start_dn ? SHAPE_DOWN : SHAPE_UP;
        base_q  <= dac_code;
        tgt_q   <= start_tgt;
        step_j  <= '0;
        prev_pt <= '0;
      end else if (busy && tick) begin
        dac_valid <= 1'b1;
        if (step_j == LAST_J) begin
          dac_code <= tgt_q;
          busy     <= 1'b0;
        end else begin
          dac_code <= interp_lvl;
          step_j   <= step_j + 1'b1;
          if (sub == SUB_END) prev_pt <= cur_pt;
        end
      end
    end
  end

  // held trigger: newest strobe wins
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v   <= 1'b0;
      pend_dn  <= 1'b0;
      pend_lvl <= '0;
    end else if (trig_now && !(start && !pend_v)) begin
      pend_v   <= 1'b1;
      pend_dn  <= down_strobe;
      pend_lvl <= burst_level;
    end else if (start && pend_v) begin
      pend_v <= 1'b0;
    end
  end

  assert_valid_single_R4: assert property (@(posedge clk) disable iff (rst)
    dac_valid |=> !dac_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !dac_valid |-> dac_code == $past(dac_code));

  assert_final_target_R6: assert property (@(posedge clk) disable iff (rst)
    (dac_valid && !busy) |-> dac_code == tgt_q);

  assert_within_span_R5: assert property (@(posedge clk) disable iff (rst)
    (dac_valid && busy) |->
      (dac_code >= ((base_q < tgt_q) ? base_q : tgt_q)) &&
      (dac_code <= ((base_q < tgt_q) ? tgt_q : base_q)));

  assert_held_starts_R8: assert property (@(posedge clk) disable iff (rst)
    (pend_v && !busy) |=> busy);

  assert_down_priority_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !pend_v && up_strobe && down_strobe) |=> kind_q == SHAPE_DOWN);
endmodule

// File: tb/ramp_env_gen_test.sv
module ramp_env_gen_test;
  localparam int STEP = 6;
  localparam int NVEC = 6;
  // {down, level}
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b0, 10'd800}, {1'b1, 10'd300}, {1'b0, 10'd1000},
    {1'b1, 10'd0},   {1'b0, 10'd1023}, {1'b1, 10'd0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       shape_we = 1'b0, shape_sel = 1'b0;
  logic [3:0] shape_addr = '0;
  logic [4:0] shape_wdata = '0;
  logic [9:0] burst_level = '0;
  logic       up_strobe = 1'b0, down_strobe = 1'b0;
  logic [9:0] dac_code;
  logic       dac_valid;

  int checks = 0, fails = 0, cur = 0;
  int up_tab [16];
  int dn_tab [16];

  ramp_env_gen uut (
    .clk(clk), .rst(rst), .shape_we(shape_we), .shape_sel(shape_sel),
    .shape_addr(shape_addr), .shape_wdata(shape_wdata),
    .burst_level(burst_level), .up_strobe(up_strobe), .down_strobe(down_strobe),
    .dac_code(dac_code), .dac_valid(dac_valid)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int model(int base, int tgt, bit dn, int j);
    int k, s, p, c, f, v;
    if (j == 64) return tgt;
    k = j / 4; s = j % 4;
    c = dn ? dn_tab[k] : up_tab[k];
    p = (k == 0) ? 0 : (dn ? dn_tab[k-1] : up_tab[k-1]);
    f = p * (4 - s) + c * s;
    v = base + (((tgt - base) * f) >>> 7);
    if (v < 0) v = 0;
    if (v > 1023) v = 1023;
    return v;
  endfunction

  task automatic pulse(input logic u, input logic d, input int lvl);
    @(negedge clk);
    up_strobe = u; down_strobe = d; burst_level = lvl[9:0];
    @(posedge clk); #1;
    up_strobe = 1'b0; down_strobe = 1'b0;
  endtask

  task automatic follow(input int base, input int tgt, input bit dn,
                        input int jfrom, input string tag);
    for (int j = jfrom; j <= 64; j++) begin
      repeat (STEP - 1) @(posedge clk);
      #1 check(dac_valid == 1'b0, "R4 idle gap", dac_valid, 0);
      @(posedge clk); #1;
      check(dac_valid == 1'b1, "R4 update", dac_valid, 1);
      check(int'(dac_code) == model(base, tgt, dn, j),
            (j == 64) ? "R6" : ((j == 0) ? "R3" : tag),
            dac_code, model(base, tgt, dn, j));
    end
  endtask

  task automatic write_pt(input logic sel, input int idx, input int val);
    @(negedge clk);
    shape_we = 1'b1; shape_sel = sel; shape_addr = idx[3:0]; shape_wdata = val[4:0];
    @(negedge clk);
    shape_we = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      up_tab[i] = 2 * i + 1;
      dn_tab[i] = (i * i) / 8;
    end
    repeat (3) @(posedge clk);
    #1 check(dac_code == 0 && dac_valid == 0, "R1 in reset", {dac_valid, dac_code}, 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check(dac_code == 0 && dac_valid == 0, "R1 after reset", {dac_valid, dac_code}, 0);

    // R2: load both tables through the write port
    for (int i = 0; i < 16; i++) begin
      write_pt(1'b0, i, up_tab[i]);
      write_pt(1'b1, i, dn_tab[i]);
    end

    // vector table: R3, R5, R6 over single and chained bursts
    for (int v = 0; v < NVEC; v++) begin
      pulse(!VEC[v][10], VEC[v][10], int'(VEC[v][9:0]));
      follow(cur, int'(VEC[v][9:0]), VEC[v][10], 0, "R5 R2");
      cur = int'(VEC[v][9:0]);
    end

    // R7: output holds zero after the final ramp-down
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      check(dac_code == 0 && dac_valid == 0, "R7 hold", {dac_valid, dac_code}, 0);
    end

    // R8: two strobes during a ramp, the later one is held
    pulse(1'b1, 1'b0, 500);
    repeat (30) @(posedge clk);
    pulse(1'b0, 1'b1, 100);
    pulse(1'b0, 1'b1, 200);
    repeat (390 - 32) @(posedge clk); #1;
    check(dac_valid == 1'b1 && dac_code == 500, "R8 first ramp end", dac_code, 500);
    repeat (STEP) @(posedge clk); #1;
    check(dac_valid == 1'b0, "R8 gap", dac_valid, 0);
    @(posedge clk); #1;
    check(dac_valid == 1'b1 && int'(dac_code) == model(500, 200, 1'b1, 0),
          "R8 held start", dac_code, model(500, 200, 1'b1, 0));
    follow(500, 200, 1'b1, 1, "R8 held ramp");
    cur = 200;

    // R9: both strobes together pick the down table
    pulse(1'b1, 1'b1, 600);
    follow(200, 600, 1'b1, 0, "R9");
    cur = 600;

    // R7: holds the last level between ramps
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1;
      check(dac_code == 600 && dac_valid == 0, "R7 hold level", dac_code, 600);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule